// File: doc/BRIEF.md
# Multi-Level Event Interrupt Aggregator

This block gathers ninety-six one-cycle event pulses from on-chip peripherals into three 32-bit sticky status words and turns them into three level-sensitive interrupt requests of different processor priority. Each request output has its own mask bank covering all ninety-six events, so software can steer any event to any priority, to several priorities at once, or to none. Software clears a pending event by writing a one to its status bit.

To spare the handler a bit scan, the block also offers, for each request output, a read-only word holding the lowest-numbered event that is both pending and enabled for that output, with a valid flag. All registers sit on a simple 32-bit bus with byte address, write enable, write data and combinational read data.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A pulse on `evt_pulse[n]` sets status bit n mod 32 of status word n/32 on the next clock edge. Status words 0, 1, 2 are read at byte offsets 0x00, 0x04, 0x08.
- R2: A status bit stays set through any number of cycles until software clears it.
- R3: A write to a status word clears exactly the bits written as one; bits written as zero keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set after the edge.
- R5: Mask bank L (L = 0, 1, 2) holds three words at byte offset 0x10*(L+1) + 4*w for status word w; a write stores the full word and a read returns it.
- R6: `irq_req[L]` is registered: it is high in the cycle after any status bit is set together with the matching bit of mask bank L. Bit 0 serves priority level 13, bit 1 level 11, bit 2 level 9.
- R7: A pending event whose mask bit is clear in bank L never raises `irq_req[L]`; `irq_req[L]` falls one cycle after its last qualifying bit is cleared or masked.
- R8: The word at byte offset 0x40 + 4*L returns bit 31 = 1 and bits 6:0 = the lowest event index pending and enabled in bank L (search from event 0 upward); it reads zero when there is none.
- R9: Reads of any unmapped offset (including offsets not a multiple of four) return zero, and writes to unmapped or read-only offsets change no register.
- R10: After reset all status words and all mask words read zero and all `irq_req` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 96 | One-cycle event pulses, bit n is event n |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 3 | Level interrupt requests, bit 0 highest priority (13) |

## Verification
Read data follows the address in the same cycle, while status words, mask words and first-pending words change one edge after the pulse or write that moves them, and each request output lags the status and mask state by one further edge. The bench keeps a model of status and masks, pushes the expected request value for every driven edge into a queue before that edge, and a monitor pops and compares it two time units after the edge. Register reads are made half a cycle after the last driven edge with no write active, so every value read is already settled.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 3;
    localparam int NUM_LEVELS = 3;
    localparam int NUM_EVENTS = NUM_WORDS * WORD_W;
    localparam int ADDR_W     = 8;
    localparam int IDX_W      = $clog2(NUM_EVENTS);
    localparam int LVL_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;
    localparam int WSEL_W     = 2;   // address bits [3:2] pick the word in a group

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_STATUS = 2'd1,
        KIND_MASK   = 2'd2,
        KIND_FIRST  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [LVL_W-1:0]  level;
        logic [WSEL_W-1:0] word;
    } reg_dec_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] index;
    } first_hit_t;

    // Group 0: status, groups 1..nl: mask banks, group nl+1: first-pending words.
    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int nw, input int nl);
        reg_dec_t d;
        int       grp;
        int       wrd;
        grp     = int'(a[ADDR_W-1:4]);
        wrd     = int'(a[3:2]);
        d.kind  = KIND_NONE;
        d.level = '0;
        d.word  = a[3:2];
        if (a[1:0] == 2'b00) begin
            if (grp == 0 && wrd < nw) begin
                d.kind = KIND_STATUS;
            end else if (grp >= 1 && grp <= nl && wrd < nw) begin
                d.kind  = KIND_MASK;
                d.level = LVL_W'(grp - 1);
            end else if (grp == nl + 1 && wrd < nl) begin
                d.kind  = KIND_FIRST;
                d.level = LVL_W'(wrd);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
    import evt_agg_pkg::*;
#(
    parameter int NW = NUM_WORDS,
    parameter int WW = WORD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NW-1:0][WW-1:0]  evt_i,
    input  logic [NW-1:0]          clr_sel_i,
    input  logic [WW-1:0]          clr_data_i,
    output logic [NW-1:0][WW-1:0]  status_o
);

    logic [NW-1:0][WW-1:0] status_q;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [WW-1:0] clr_bits;
        assign clr_bits = {WW{clr_sel_i[w]}} & clr_data_i;

        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[w] <= '0;
            end else begin
                status_q[w] <= (status_q[w] & ~clr_bits) | evt_i[w];
            end
        end

        // R1: every pulsed bit is set after the edge
        a_r1_pulse_sets: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((status_q[w] & $past(evt_i[w])) == $past(evt_i[w])));

        // R2: a bit only falls where a clear was written
        a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((($past(status_q[w]) & ~status_q[w])
                       & ~$past({WW{clr_sel_i[w]}} & clr_data_i)) == '0));

        // R3: bits written as one without a new event are gone
        a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            clr_sel_i[w] |=> ((status_q[w] & $past(clr_data_i & ~evt_i[w])) == '0));

        // R4: event beats a same-cycle clear
        a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
            (clr_sel_i[w] && ((evt_i[w] & clr_data_i) != '0))
            |=> ((status_q[w] & $past(evt_i[w] & clr_data_i)) == $past(evt_i[w] & clr_data_i)));
    end

    assign status_o = status_q;

endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
    import evt_agg_pkg::*;
#(
    parameter int NW = NUM_WORDS,
    parameter int WW = WORD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NW-1:0]          wr_sel_i,
    input  logic [WW-1:0]          wr_data_i,
    input  logic [NW-1:0][WW-1:0]  status_i,
    output logic [NW-1:0][WW-1:0]  mask_o,
    output logic [NW*WW-1:0]       hit_o,
    output logic                   irq_o
);

    logic [NW-1:0][WW-1:0] mask_q;
    logic                  irq_q;

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[w] <= '0;
            end else if (wr_sel_i[w]) begin
                mask_q[w] <= wr_data_i;
            end
        end

        assign hit_o[w*WW +: WW] = status_i[w] & mask_q[w];

        // R5: a selected write lands in full
        a_r5_mask_store: assert property (@(posedge clk) disable iff (rst)
            wr_sel_i[w] |=> (mask_q[w] == $past(wr_data_i)));

        // R5: an unselected word holds
        a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
            !wr_sel_i[w] |=> $stable(mask_q[w]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |hit_o;
        end
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/evt_first_finder.sv
module evt_first_finder
    import evt_agg_pkg::*;
#(
    parameter int NE = NUM_EVENTS,
    parameter int IW = IDX_W
) (
    input  logic [NE-1:0] hit_i,
    output logic          valid_o,
    output logic [IW-1:0] index_o
);

    // Scan from the top down so the last match kept is the lowest index.
    always_comb begin
        valid_o = 1'b0;
        index_o = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                valid_o = 1'b1;
                index_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
    import evt_agg_pkg::*;
#(
    parameter int NW = NUM_WORDS,
    parameter int WW = WORD_W,
    parameter int NL = NUM_LEVELS,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NW*WW-1:0] evt_pulse,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [WW-1:0]    bus_wdata,
    output logic [WW-1:0]    bus_rdata,
    output logic [NL-1:0]    irq_req
);

    localparam int NE = NW * WW;
    localparam int IW = $clog2(NE);

    reg_dec_t                      dec;
    logic [NW-1:0]                 clr_sel;
    logic [NW-1:0][WW-1:0]         status_w;
    logic [NL-1:0][NW-1:0][WW-1:0] mask_w;
    logic [NL-1:0][NE-1:0]         hit_w;
    first_hit_t [NL-1:0]           first_w;

    assign dec = decode_addr(bus_addr, NW, NL);

    for (genvar w = 0; w < NW; w++) begin : g_clr
        assign clr_sel[w] = bus_we && (dec.kind == KIND_STATUS) && (int'(dec.word) == w);
    end

    evt_status_bank #(.NW(NW), .WW(WW)) u_status (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt_pulse),
        .clr_sel_i  (clr_sel),
        .clr_data_i (bus_wdata),
        .status_o   (status_w)
    );

    for (genvar g = 0; g < NL; g++) begin : g_level
        logic [NW-1:0] mask_sel;
        logic          f_valid;
        logic [IW-1:0] f_index;

        for (genvar w = 0; w < NW; w++) begin : g_sel
            assign mask_sel[w] = bus_we && (dec.kind == KIND_MASK)
                               && (int'(dec.level) == g) && (int'(dec.word) == w);
        end

        evt_mask_bank #(.NW(NW), .WW(WW)) u_mask (
            .clk       (clk),
            .rst       (rst),
            .wr_sel_i  (mask_sel),
            .wr_data_i (bus_wdata),
            .status_i  (status_w),
            .mask_o    (mask_w[g]),
            .hit_o     (hit_w[g]),
            .irq_o     (irq_req[g])
        );

        evt_first_finder #(.NE(NE), .IW(IW)) u_first (
            .hit_i   (hit_w[g]),
            .valid_o (f_valid),
            .index_o (f_index)
        );

        assign first_w[g].valid = f_valid;
        assign first_w[g].index = IDX_W'(f_index);

        // R6: qualifying pending state raises the request next cycle
        a_r6_irq_rise: assert property (@(posedge clk) disable iff (rst)
            ((status_w & mask_w[g]) != '0) |=> irq_req[g]);

        // R7: without a qualifying bit the request is low next cycle
        a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
            ((status_w & mask_w[g]) == '0) |=> !irq_req[g]);

        // R8: reported index is pending and enabled, with nothing lower
        a_r8_first_hit: assert property (@(posedge clk) disable iff (rst)
            first_w[g].valid |-> (hit_w[g][first_w[g].index]
                && ((hit_w[g] & ~({NE{1'b1}} << first_w[g].index)) == '0)));

        // R8: no valid flag means nothing pending and enabled
        a_r8_first_none: assert property (@(posedge clk) disable iff (rst)
            !first_w[g].valid |-> (hit_w[g] == '0));
    end

    always_comb begin
        bus_rdata = '0;
        unique case (dec.kind)
            KIND_STATUS: bus_rdata = status_w[dec.word];
            KIND_MASK:   bus_rdata = mask_w[dec.level][dec.word];
            KIND_FIRST:  bus_rdata = {first_w[dec.level].valid,
                                      {(WW - 1 - IDX_W){1'b0}},
                                      first_w[dec.level].index};
            default:     bus_rdata = '0;
        endcase
    end

    // R9: unmapped offsets read zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == KIND_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/evt_irq_aggregator_bench.sv
module evt_irq_aggregator_bench;

    localparam int CLK_P = 10;
    localparam int NE    = 96;

    logic        clk = 1'b0;
    logic        rst;
    logic [95:0] evt_pulse;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_req;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_status [3];
    logic [31:0] m_mask   [3][3];
    logic [2:0]  exp_q [$];

    always #(CLK_P/2) clk = ~clk;

    evt_irq_aggregator u_evt_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );

    function automatic logic [95:0] ev1(input int n);
        return 96'(1) << n;
    endfunction

    function automatic logic [31:0] model_first(input int l);
        for (int n = 0; n < NE; n++) begin
            if (m_status[n / 32][n % 32] && m_mask[l][n / 32][n % 32])
                return 32'h8000_0000 | 32'(n);
        end
        return 32'h0;
    endfunction

    // Driver: one clock edge of stimulus; pushes the request value due after it.
    task automatic step(input logic [95:0] ev, input logic we,
                        input logic [7:0] a, input logic [31:0] d);
        logic [2:0]  e;
        logic [31:0] clr;
        for (int l = 0; l < 3; l++) begin
            e[l] = 1'b0;
            for (int w = 0; w < 3; w++)
                if ((m_status[w] & m_mask[l][w]) != 0) e[l] = 1'b1;
        end
        exp_q.push_back(e);
        for (int w = 0; w < 3; w++) begin
            clr = (we && a == 8'(4 * w)) ? d : 32'h0;
            m_status[w] = (m_status[w] & ~clr) | ev[w*32 +: 32];
        end
        for (int l = 0; l < 3; l++)
            for (int w = 0; w < 3; w++)
                if (we && a == 8'(16 * (l + 1) + 4 * w)) m_mask[l][w] = d;
        evt_pulse = ev;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        evt_pulse = '0;
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic chk_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
        end
    endtask

    // Monitor: compares each request value two units after its edge.
    initial begin
        logic [2:0] e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (irq_req !== e) begin
                    n_fail++;
                    $display("FAIL R6/R7: irq_req got %b expected %b at %0t", irq_req, e, $time);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int w = 0; w < 3; w++) begin
            m_status[w] = '0;
            for (int l = 0; l < 3; l++) m_mask[l][w] = '0;
        end
        rst = 1'b1; evt_pulse = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset state
        for (int w = 0; w < 3; w++) begin
            chk_read(8'(4 * w), 32'h0, "R10 status");
            for (int l = 0; l < 3; l++) chk_read(8'(16 * (l + 1) + 4 * w), 32'h0, "R10 mask");
        end
        n_checks++;
        if (irq_req !== 3'b000) begin
            n_fail++;
            $display("FAIL R10: irq_req got %b expected 000", irq_req);
        end

        // R5: mask write and readback
        step('0, 1'b1, 8'h10, 32'h0000_0010);
        chk_read(8'h10, 32'h0000_0010, "R5 bank0 word0");
        chk_read(8'h14, 32'h0, "R5 bank0 word1 untouched");

        // R1, R6, R8: event 4 enabled in bank 0
        step(ev1(4), 1'b0, 8'h00, 32'h0);
        idle(2);
        chk_read(8'h00, 32'h0000_0010, "R1 status0 bit4");
        chk_read(8'h40, 32'h8000_0004, "R8 first0 event4");
        chk_read(8'h44, 32'h0, "R8 first1 none");

        // R7: event 40 pending but enabled nowhere
        step(ev1(40), 1'b0, 8'h00, 32'h0);
        idle(2);
        chk_read(8'h04, 32'h0000_0100, "R1 status1 bit8");
        chk_read(8'h48, 32'h0, "R7 first2 none while masked");

        // R5, R6, R8: enable event 40 in bank 2
        step('0, 1'b1, 8'h34, 32'h0000_0100);
        idle(2);
        chk_read(8'h48, 32'h8000_0028, "R8 first2 event40");

        // R3: writing zeros leaves status, writing one clears
        step('0, 1'b1, 8'h04, 32'h0);
        chk_read(8'h04, 32'h0000_0100, "R3 zero write keeps");
        step('0, 1'b1, 8'h00, 32'h0000_0010);
        idle(2);
        chk_read(8'h00, 32'h0, "R3 clear bit4");
        chk_read(8'h40, 32'h0, "R7 first0 gone after clear");

        // R4: event 70 pulse and clear of bit 70 in the same cycle
        step(ev1(70), 1'b1, 8'h08, 32'h0000_0040);
        chk_read(8'h08, 32'h0000_0040, "R4 event wins");

        // R8: lowest of 95 and 70 in bank 1
        step(ev1(95), 1'b1, 8'h28, 32'h8000_0040);
        idle(2);
        chk_read(8'h44, 32'h8000_0046, "R8 first1 lowest 70");
        chk_read(8'h44, model_first(1), "R8 first1 model");
        step('0, 1'b1, 8'h08, 32'h0000_0040);
        idle(2);
        chk_read(8'h44, 32'h8000_005F, "R8 first1 next 95");

        // R7: masking drops irq 2
        step('0, 1'b1, 8'h34, 32'h0);
        idle(2);
        chk_read(8'h04, 32'h0000_0100, "R2 status1 kept while masked");

        // R9: unmapped reads and ignored writes
        chk_read(8'h0C, 32'h0, "R9 read 0x0C");
        chk_read(8'h1C, 32'h0, "R9 read 0x1C");
        chk_read(8'h4C, 32'h0, "R9 read 0x4C");
        chk_read(8'h50, 32'h0, "R9 read 0x50");
        chk_read(8'h12, 32'h0, "R9 read 0x12");
        step('0, 1'b1, 8'h1C, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h44, 32'h0);
        step('0, 1'b1, 8'h11, 32'hFFFF_FFFF);
        idle(1);
        chk_read(8'h10, 32'h0000_0010, "R9 bank0 unchanged");
        chk_read(8'h44, 32'h8000_005F, "R9 first1 unchanged");
        chk_read(8'h08, 32'h8000_0000, "R9 status2 unchanged");

        // R2: status holds across idle cycles
        idle(10);
        chk_read(8'h04, 32'h0000_0100, "R2 sticky after idle");

        // R1, R6: every event at once, then clear all
        step({96{1'b1}}, 1'b0, 8'h00, 32'h0);
        idle(2);
        chk_read(8'h00, 32'hFFFF_FFFF, "R1 all status0");
        chk_read(8'h04, 32'hFFFF_FFFF, "R1 all status1");
        chk_read(8'h08, 32'hFFFF_FFFF, "R1 all status2");
        chk_read(8'h40, 32'h8000_0004, "R8 first0 all pending");
        for (int w = 0; w < 3; w++) step('0, 1'b1, 8'(4 * w), 32'hFFFF_FFFF);
        idle(3);
        for (int w = 0; w < 3; w++) chk_read(8'(4 * w), 32'h0, "R3 all cleared");
        chk_read(8'h44, 32'h0, "R8 first1 none after clear");

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule